// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block links a synchronous single-word request port to an asynchronous DRAM whose address pins are shared by the row and the column. A requester presents a 21-bit byte address, a direction flag and write data while `busy` is low. The controller then drives the DRAM pins in sequence. The upper 12 address bits go out first and are captured by pulling the row strobe low. The lower 9 bits follow on the same pins and are captured by the column strobe. The access ends with a one-cycle `done` pulse. On a read, the fetched byte is valid in that same cycle.

The cells keep their charge for 64 ms. Between accesses the controller inserts row-strobe-only refresh cycles, walking an internal row counter through all 4096 rows. A refresh that falls due waits for any access in progress to finish. Once the controller is idle, the refresh goes ahead of any new request. All strobe timings are parameters counted in clock cycles.

Top module: `dram_addr_ctrl`

## Requirements
- R1: During and after a synchronous reset, `busy` and `done` are 0, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `dram_dq_oe` is 0.
- R2: For an access to address A, `dram_addr` holds A[20:9] when `dram_ras_n` falls. When `dram_cas_n` falls, `dram_addr` holds A[8:0] in bits 8..0 with bits 11..9 at zero.
- R3: `dram_addr` holds the row value for at least one cycle before `dram_ras_n` falls. `dram_cas_n` falls exactly T_RCD+1 cycles after `dram_ras_n` falls, with the column value already on `dram_addr` in the cycle before. `dram_cas_n` stays low for exactly T_CAS cycles and is never low while `dram_ras_n` is high.
- R4: On a write (`req_write`=1), `dram_we_n` is 0 and `dram_dq_oe` is 1 with the request data on `dram_dq_out`, from the cycle before `dram_cas_n` falls until it rises. On a read, `dram_we_n` stays 1.
- R5: On a read, `rd_data` takes the value of `dram_dq_in` at the last clock edge of the column strobe's low phase. At that same edge `done` rises for exactly one cycle, and `rd_data` is valid while `done` is high.
- R6: After any access or refresh, `dram_ras_n` stays high for at least T_RP+2 cycles before it falls again.
- R7: A request is taken at a rising edge where `req_valid` is 1 and `busy` is 0. `busy` is then 1 until the access has finished its precharge. A request presented while `busy` is 1 is ignored: it produces no DRAM cycle, no stored data and no `done`. Each accepted request produces exactly one `done`.
- R8: A refresh keeps `dram_cas_n` high and holds `dram_ras_n` low for T_RCD cycles. It uses a row from an internal counter that starts at 0 after reset and advances by one (mod 4096) per refresh. One refresh falls due every REF_INTERVAL cycles; the default of 781 is 64 ms / 4096 rows at 50 MHz.
- R9: A refresh that is due raises `busy`. It never starts during an access, and it starts before any further request once the controller is idle. Consecutive refresh row-strobe falls are never more than REF_INTERVAL + T_RCD + T_CAS + T_RP + 8 cycles apart, even under back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address: row in [20:9], column in [8:0] |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access or refresh under way or due; requests ignored |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 8 | Read data, valid with `done` |
| dram_addr | output | 12 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The bound checker watches the strobe rules on every cycle:
- the column strobe only low under a low row strobe;
- the address and write enable steady across each strobe fall;
- the data driver enabled whenever write enable is low;
- `done` single-cycle and inside `busy`.

The exact strobe spacing, the row and column values seen by the DRAM, the read data and the ignored requests can only be shown by the bench's scenarios. These checks run against a behavioural DRAM model and a scoreboard. The same holds for the refresh row sequence and the bounded refresh spacing under continuous load.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_PRE
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_ROW,
    SEL_COL,
    SEL_REF
  } addr_sel_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 781,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pend,
  output logic             pend_nxt,
  output logic [ROW_W-1:0] row
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = (cnt == CW'(INTERVAL - 1));
  assign pend_nxt = (pend & ~ack) | tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
      row  <= '0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      pend <= pend_nxt;
      if (ack) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_step_timer.sv
module dram_step_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 9
) (
  input  addr_sel_t              sel,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [ROW_W-1:0]       ref_row,
  output logic [ROW_W-1:0]       bus
);
  always_comb begin
    unique case (sel)
      SEL_ROW: bus = addr[ROW_W+COL_W-1:COL_W];
      SEL_COL: bus = ROW_W'(addr[COL_W-1:0]);
      default: bus = ref_row;
    endcase
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int TW     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W-1:0]      dq_in,
  input  logic                   pend,
  input  logic                   pend_nxt,
  input  logic [ROW_W-1:0]       mux_bus,
  input  logic                   tmr_zero,
  output logic                   ref_ack,
  output addr_sel_t              mux_sel,
  output logic [ROW_W+COL_W-1:0] mux_addr,
  output logic                   tmr_load,
  output logic [TW-1:0]          tmr_val,
  output logic                   busy,
  output logic                   done,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ROW_W-1:0]       bus_addr,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   dq_oe
);
  localparam int AW = ROW_W + COL_W;

  seq_state_t        state, state_nxt;
  logic              accept;
  logic              is_ref;
  logic              lat_wr;
  logic [AW-1:0]     lat_addr;
  logic [DATA_W-1:0] lat_data;

  // next state, timer loads and handshakes
  always_comb begin
    state_nxt = state;
    accept    = 1'b0;
    ref_ack   = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE: begin
        if (pend) begin
          ref_ack   = 1'b1;
          state_nxt = ST_ROW;
        end else if (req_valid && !busy) begin
          accept    = 1'b1;
          state_nxt = ST_ROW;
        end
      end
      ST_ROW: begin
        tmr_load  = 1'b1;
        tmr_val   = TW'(T_RCD - 1);
        state_nxt = ST_RAS;
      end
      ST_RAS: begin
        if (tmr_zero) begin
          if (is_ref) begin
            tmr_load  = 1'b1;
            tmr_val   = TW'(T_RP - 1);
            state_nxt = ST_PRE;
          end else begin
            state_nxt = ST_COL;
          end
        end
      end
      ST_COL: begin
        tmr_load  = 1'b1;
        tmr_val   = TW'(T_CAS - 1);
        state_nxt = ST_CAS;
      end
      ST_CAS: begin
        if (tmr_zero) begin
          tmr_load  = 1'b1;
          tmr_val   = TW'(T_RP - 1);
          state_nxt = ST_PRE;
        end
      end
      ST_PRE: begin
        if (tmr_zero) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  // address source for the multiplexer
  always_comb begin
    mux_addr = (state == ST_IDLE) ? req_addr : lat_addr;
    if (state == ST_IDLE) mux_sel = pend ? SEL_REF : SEL_ROW;
    else                  mux_sel = SEL_COL;
  end

  // registered pins and request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      bus_addr <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      is_ref   <= 1'b0;
      lat_wr   <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      state <= state_nxt;
      busy  <= (state_nxt != ST_IDLE) || pend_nxt;
      done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_ack) begin
            is_ref   <= 1'b1;
            bus_addr <= mux_bus;
          end else if (accept) begin
            is_ref   <= 1'b0;
            lat_wr   <= req_write;
            lat_addr <= req_addr;
            lat_data <= req_wdata;
            bus_addr <= mux_bus;
          end
        end
        ST_ROW: ras_n <= 1'b0;
        ST_RAS: begin
          if (tmr_zero) begin
            if (is_ref) begin
              ras_n <= 1'b1;
            end else begin
              bus_addr <= mux_bus;
              we_n     <= ~lat_wr;
              dq_oe    <= lat_wr;
              dq_out   <= lat_data;
            end
          end
        end
        ST_COL: cas_n <= 1'b0;
        ST_CAS: begin
          if (tmr_zero) begin
            if (!lat_wr) rd_data <= dq_in;
            done  <= 1'b1;
            cas_n <= 1'b1;
            ras_n <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 781
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   busy,
  output logic                   done,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int AW   = ROW_W + COL_W;
  localparam int MAXD = max3(T_RCD, T_CAS, T_RP);
  localparam int TW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic             pend, pend_nxt, ref_ack;
  logic [ROW_W-1:0] ref_row;
  addr_sel_t        mux_sel;
  logic [AW-1:0]    mux_addr;
  logic [ROW_W-1:0] mux_bus;
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;

  dram_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack),
    .pend(pend), .pend_nxt(pend_nxt), .row(ref_row)
  );

  dram_step_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .sel(mux_sel), .addr(mux_addr), .ref_row(ref_row), .bus(mux_bus)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .TW(TW)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .dq_in(dram_dq_in), .pend(pend), .pend_nxt(pend_nxt),
    .mux_bus(mux_bus), .tmr_zero(tmr_zero),
    .ref_ack(ref_ack), .mux_sel(mux_sel), .mux_addr(mux_addr),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr(dram_addr), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe)
  );
endmodule

// File: rtl/dram_addr_ctrl_chk.sv
module dram_addr_ctrl_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic [AW-1:0] bus_addr
);
  // R3
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);
  // R3
  row_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(bus_addr));
  // R3
  col_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> ($stable(bus_addr) && $past(!ras_n)));
  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $stable(we_n));
  // R4
  we_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  // R7
  ras_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> busy);
endmodule

bind dram_addr_ctrl dram_addr_ctrl_chk #(.AW(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .dq_oe(dram_dq_oe), .bus_addr(dram_addr)
);

// File: tb/dram_addr_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_addr_ctrl_tb_top;
  localparam int ROW_W   = 12;
  localparam int COL_W   = 9;
  localparam int AW      = ROW_W + COL_W;
  localparam int DW      = 8;
  localparam int T_RCD   = 2;
  localparam int T_CAS   = 3;
  localparam int T_RP    = 2;
  localparam int REF_INT = 300;
  localparam int SLACK   = T_RCD + T_CAS + T_RP + 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [DW-1:0] rd_data, dram_dq_out;
  logic [DW-1:0] dram_dq_in = '0;
  logic [ROW_W-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;

  always #10 clk = ~clk;

  dram_addr_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_INT)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int issued = 0, done_cnt = 0, ref_cnt = 0;
  item_t exp_q[$];
  logic [DW-1:0] shadow [logic [AW-1:0]];
  logic [DW-1:0] mem    [logic [AW-1:0]];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] patt(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: waits for a free controller, presents one request, queues expectation
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    it.wr = wr; it.addr = a;
    if (wr) begin
      it.data = d; shadow[a] = d;
    end else begin
      it.data = shadow.exists(a) ? shadow[a] : patt(a);
    end
    exp_q.push_back(it);
    issued++;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R7 busy after accept", {31'b0, busy}, 1);
  endtask

  // DRAM model and monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_done = 1'b0, cas_seen = 1'b0;
  logic [ROW_W-1:0] row_l = '0;
  logic [ROW_W-1:0] ref_exp = '0;
  int ras_fall_cyc = 0, ras_rise_cyc = 0, cas_fall_cyc = 0, last_ref = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        chk(dram_cas_n, "R3 cas high at ras fall", {31'b0, dram_cas_n}, 1);
        chk(cyc - ras_rise_cyc >= T_RP + 2, "R6 precharge",
            cyc - ras_rise_cyc, T_RP + 2);
        row_l = dram_addr; ras_fall_cyc = cyc; cas_seen = 1'b0;
      end
      if (prev_cas && !dram_cas_n) begin
        item_t h;
        logic [AW-1:0] ma;
        cas_seen = 1'b1; cas_fall_cyc = cyc;
        chk(cyc - ras_fall_cyc == T_RCD + 1, "R3 ras-to-cas",
            cyc - ras_fall_cyc, T_RCD + 1);
        ma = {row_l, dram_addr[COL_W-1:0]};
        if (exp_q.size() > 0) begin
          h = exp_q[0];
          chk(row_l == h.addr[AW-1:COL_W], "R2 row", row_l, h.addr[AW-1:COL_W]);
          chk(dram_addr == ROW_W'(h.addr[COL_W-1:0]), "R2 column",
              dram_addr, h.addr[COL_W-1:0]);
          chk(dram_we_n == !h.wr, "R4 write enable", dram_we_n, !h.wr);
          if (h.wr)
            chk(dram_dq_oe && dram_dq_out == h.data, "R4 write data",
                dram_dq_out, h.data);
        end else begin
          chk(1'b0, "R7 access without request", ma, 0);
        end
        if (!dram_we_n) mem[ma] = dram_dq_out;
        dram_dq_in = mem.exists(ma) ? mem[ma] : patt(ma);
      end
      if (!prev_cas && dram_cas_n)
        chk(cyc - cas_fall_cyc == T_CAS, "R3 cas width", cyc - cas_fall_cyc, T_CAS);
      if (!prev_ras && dram_ras_n) begin
        if (!cas_seen) begin
          chk(row_l == ref_exp, "R8 refresh row", row_l, ref_exp);
          chk(cyc - ras_fall_cyc == T_RCD, "R8 refresh strobe width",
              cyc - ras_fall_cyc, T_RCD);
          chk(ras_fall_cyc - last_ref <= REF_INT + SLACK, "R9 refresh spacing",
              ras_fall_cyc - last_ref, REF_INT + SLACK);
          last_ref = ras_fall_cyc;
          ref_exp  = ref_exp + 1'b1;
          ref_cnt++;
        end
        ras_rise_cyc = cyc;
      end
      if (done) begin
        item_t h;
        chk(!prev_done, "R5 done single cycle", {31'b0, prev_done}, 0);
        done_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 done without request", 1, 0);
        end else begin
          h = exp_q.pop_front();
          if (!h.wr)
            chk(rd_data == h.data, "R5 read data", rd_data, h.data);
          else
            chk(mem.exists(h.addr) && mem[h.addr] == h.data, "R4 stored byte",
                mem.exists(h.addr) ? mem[h.addr] : 8'h00, h.data);
        end
      end
      prev_ras  = dram_ras_n;
      prev_cas  = dram_cas_n;
      prev_done = done;
    end
  end

  task automatic run_test();
    repeat (4) @(negedge clk);
    chk(!busy && !done && dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe,
        "R1 in reset", {busy, done, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe},
        6'b001110);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe,
        "R1 after reset", {busy, done, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe},
        6'b001110);
    // R2 R4 corner addresses
    issue(1'b1, 21'h000000, 8'h5A);
    issue(1'b1, 21'h1FFFFF, 8'hA5);
    issue(1'b1, 21'h1FF000, 8'h3C);
    issue(1'b1, 21'h0001FF, 8'hC3);
    // R5 read back plus an unwritten location
    issue(1'b0, 21'h000000, 8'h00);
    issue(1'b0, 21'h1FFFFF, 8'h00);
    issue(1'b0, 21'h1FF000, 8'h00);
    issue(1'b0, 21'h0001FF, 8'h00);
    issue(1'b0, 21'h0ABCDE, 8'h00);
    // R7 a write offered while busy must be dropped
    issue(1'b0, 21'h012345, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h0F0F0F; req_wdata = 8'hEE;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    // R8 isolated refresh while idle
    repeat (REF_INT + 50) @(negedge clk);
    chk(ref_cnt >= 1, "R8 idle refresh seen", ref_cnt, 1);
    // R9 back-to-back load across many refresh intervals
    for (int i = 0; i < 150; i++)
      issue(1'b1, AW'(i * 8191 + i * 3 + 1), DW'(i * 7 + 1));
    for (int i = 0; i < 150; i++)
      issue(1'b0, AW'(i * 8191 + i * 3 + 1), 8'h00);
    // R7 dropped write left no trace
    issue(1'b0, 21'h0F0F0F, 8'h00);
    @(negedge clk);
    while (busy || exp_q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(done_cnt == issued, "R7 one done per request", done_cnt, issued);
    chk(exp_q.size() == 0, "R7 all results returned", exp_q.size(), 0);
    chk(ref_cnt >= cyc / (REF_INT + SLACK), "R8 refresh count", ref_cnt,
        cyc / (REF_INT + SLACK));
    chk(cyc - last_ref <= REF_INT + SLACK, "R9 refresh still running",
        cyc - last_ref, REF_INT + SLACK);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_test();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) chk(1'b0, "watchdog expired", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule